// File: doc/BRIEF.md
# Sign-Magnitude Cubic Polynomial Evaluator

This block evaluates a fixed third-degree polynomial, y = a0 + a1·x + a2·x² + a3·x³, on one fixed-point input sample per clock. Both x and y are carried as a separate sign bit plus an unsigned magnitude. Each magnitude is the fixed-point value with its binary point removed: x has NX fractional bits and y has NY. The four coefficients are constants fixed at build time. Each coefficient has its own magnitude, its own sign and its own fractional-bit count.

All multiplication is done on unsigned magnitudes. Each term's sign is worked out on its own from the coefficient sign and the input sign. Each product is brought to the output scale by a plain binary shift, so the block contains no divider. The rescaled terms are then added or subtracted according to their signs. The total is converted back to sign-magnitude form and registered, so the result appears one clock after the input.

Top module: `cubic_sm_eval`

## Requirements
- R1: With in_sign = 1 meaning negative and in_mag = X (the value times 2^NX), the result has magnitude |sum over k of s_k·T_k| and sign 1 when that sum is negative. Here T_k = floor(Ck·X^k / 2^e_k) when e_k = k·NX + Fk − NY ≥ 0, and T_k = Ck·X^k·2^(−e_k) otherwise.
- R2: The term signs s_k follow a fixed rule. Terms for k = 0 and k = 2 take the coefficient sign alone. Terms for k = 1 and k = 3 take the coefficient sign XOR in_sign.
- R3: An input of magnitude zero gives the same output whichever in_sign it carries. That output is the rescaled a0.
- R4: A result of magnitude zero is always reported with out_sign = 0.
- R5: When the result magnitude exceeds 2^YW − 1, out_mag is all ones and out_sign keeps the sign of the true result.
- R6: out_valid is high in exactly the cycle after a cycle in which in_valid was high. The output data in that cycle belong to that input.
- R7: While in_valid is low, out_sign and out_mag keep their previous values, whatever in_sign and in_mag do.
- R8: A synchronous reset sets out_valid, out_sign and out_mag to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present |
| in_sign | input | 1 | Sign of x, 1 = negative |
| in_mag | input | XW | Magnitude of x, NX fractional bits |
| out_valid | output | 1 | Result is present |
| out_sign | output | 1 | Sign of y, 1 = negative |
| out_mag | output | YW | Magnitude of y, NY fractional bits |

## Verification
The bench uses the default coefficients: a0 = −1.5, a1 = 0.75, a2 = −0.25 and a3 = 0.125, with NX = 4 and NY = 6. With these values the a0 term is shifted left, the a1 term is not shifted, and the a2 and a3 terms are shifted right, so all three shift paths are used. It narrows the output magnitude to YW = 12 bits. Inputs near full scale then overflow in both directions and reach the saturation path. The input x = 2.0 makes the four terms cancel exactly, which exercises the zero-sign rule. Inputs of ±1.0 show how the odd terms flip with the input sign.

// File: rtl/cubic_sm_eval.sv
module cubic_sm_eval #(
  parameter int XW = 8,
  parameter int YW = 16,
  parameter int NX = 4,
  parameter int NY = 6,
  parameter int CW = 8,
  parameter logic [CW-1:0] C0 = 3,
  parameter logic [CW-1:0] C1 = 3,
  parameter logic [CW-1:0] C2 = 2,
  parameter logic [CW-1:0] C3 = 1,
  parameter bit S0 = 1'b1,
  parameter bit S1 = 1'b0,
  parameter bit S2 = 1'b1,
  parameter bit S3 = 1'b0,
  parameter int F0 = 1,
  parameter int F1 = 2,
  parameter int F2 = 3,
  parameter int F3 = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sign,
  input  logic [XW-1:0] in_mag,
  output logic          out_valid,
  output logic          out_sign,
  output logic [YW-1:0] out_mag
);
  localparam int AW  = CW + 3*XW + NY + 3;
  localparam int SH0 = F0 - NY;
  localparam int SH1 = NX + F1 - NY;
  localparam int SH2 = 2*NX + F2 - NY;
  localparam int SH3 = 3*NX + F3 - NY;
  localparam int R0 = (SH0 > 0) ? SH0 : 0;
  localparam int L0 = (SH0 < 0) ? -SH0 : 0;
  localparam int R1 = (SH1 > 0) ? SH1 : 0;
  localparam int L1 = (SH1 < 0) ? -SH1 : 0;
  localparam int R2 = (SH2 > 0) ? SH2 : 0;
  localparam int L2 = (SH2 < 0) ? -SH2 : 0;
  localparam int R3 = (SH3 > 0) ? SH3 : 0;
  localparam int L3 = (SH3 < 0) ? -SH3 : 0;

  logic [AW-1:0] x1, x2, x3;
  logic [AW-1:0] t0, t1, t2, t3;
  logic signed [AW:0] acc;
  logic [AW:0] amag;
  logic ysign;
  logic [YW-1:0] ymag;

  assign x1 = AW'(in_mag);
  assign x2 = x1 * x1;
  assign x3 = x2 * x1;

  assign t0 = (AW'(C0) >> R0) << L0;
  assign t1 = ((AW'(C1) * x1) >> R1) << L1;
  assign t2 = ((AW'(C2) * x2) >> R2) << L2;
  assign t3 = ((AW'(C3) * x3) >> R3) << L3;

  function automatic logic signed [AW:0] fold(input logic signed [AW:0] a,
                                              input logic [AW-1:0] t,
                                              input logic neg);
    return neg ? a - $signed({1'b0, t}) : a + $signed({1'b0, t});
  endfunction

  always_comb begin
    acc = '0;
    acc = fold(acc, t0, S0);
    acc = fold(acc, t1, S1 ^ in_sign);
    acc = fold(acc, t2, S2);
    acc = fold(acc, t3, S3 ^ in_sign);
  end

  assign ysign = acc[AW];
  assign amag  = ysign ? -acc : acc;
  assign ymag  = (|amag[AW:YW]) ? '1 : amag[YW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= ysign;
        out_mag  <= ymag;
      end
    end
  end
endmodule

// File: rtl/cubic_sm_eval_chk.sv
module cubic_sm_eval_chk #(
  parameter int XW = 8,
  parameter int YW = 16,
  parameter int NY = 6,
  parameter int CW = 8,
  parameter logic [CW-1:0] C0 = 3,
  parameter bit S0 = 1'b1,
  parameter int F0 = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_sign,
  input logic [XW-1:0] in_mag,
  input logic          out_valid,
  input logic          out_sign,
  input logic [YW-1:0] out_mag
);
  localparam longint A0V  = (F0 >= NY) ? (longint'(C0) >>> (F0 - NY)) : (longint'(C0) <<< (NY - F0));
  localparam longint YMAX = (longint'(1) <<< YW) - 1;
  localparam logic [YW-1:0] A0M = (A0V > YMAX) ? '1 : YW'(A0V);
  localparam bit A0S = S0 && (A0V != 0);

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_mag) && $stable(out_sign)));
  assert_no_negative_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_mag == '0) |-> !out_sign);
  assert_zero_input_gives_a0_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mag == '0) |=> (out_mag == A0M && out_sign == A0S));
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_mag == '0 && !out_sign));
  logic unused_in_sign;
  assign unused_in_sign = in_sign;
endmodule

bind cubic_sm_eval cubic_sm_eval_chk #(
  .XW(XW), .YW(YW), .NY(NY), .CW(CW), .C0(C0), .S0(S0), .F0(F0)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
  .in_mag(in_mag), .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag)
);

// File: tb/cubic_sm_eval_test.sv
module cubic_sm_eval_test;
  localparam int XW = 8, YW = 12, NX = 4, NY = 6, CW = 8;
  localparam longint CC [0:3] = '{3, 3, 2, 1};
  localparam bit     SS [0:3] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int     FF [0:3] = '{1, 2, 3, 3};
  localparam longint MAXM = (longint'(1) <<< YW) - 1;

  localparam logic [8:0] VEC [0:11] = '{
    {1'b0, 8'd3},  {1'b0, 8'd8},   {1'b1, 8'd8},   {1'b0, 8'd20},
    {1'b1, 8'd20}, {1'b0, 8'd47},  {1'b1, 8'd47},  {1'b0, 8'd100},
    {1'b1, 8'd100},{1'b0, 8'd128}, {1'b1, 8'd200}, {1'b0, 8'd240}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_sign = 1'b0;
  logic [XW-1:0] in_mag = '0;
  logic out_valid, out_sign;
  logic [YW-1:0] out_mag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cubic_sm_eval #(
    .XW(XW), .YW(YW), .NX(NX), .NY(NY), .CW(CW),
    .C0(8'd3), .C1(8'd3), .C2(8'd2), .C3(8'd1),
    .S0(1'b1), .S1(1'b0), .S2(1'b1), .S3(1'b0),
    .F0(1), .F1(2), .F2(3), .F3(3)
  ) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_mag(in_mag), .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag)
  );

  function automatic longint term(input int k, input longint xm);
    longint p = CC[k];
    int e = k*NX + FF[k] - NY;
    for (int i = 0; i < k; i++) p = p * xm;
    if (e >= 0) return p / (longint'(1) <<< e);
    return p * (longint'(1) <<< (-e));
  endfunction

  task automatic model(input bit s, input int m, output bit es, output int em);
    longint sum = 0;
    longint a;
    for (int k = 0; k < 4; k++) begin
      bit neg = SS[k] ^ (s & k[0]);
      sum = neg ? sum - term(k, m) : sum + term(k, m);
    end
    es = (sum < 0);
    a = es ? -sum : sum;
    if (a > MAXM) a = MAXM;
    em = int'(a);
  endtask

  task automatic check(input string req, input bit ev, input bit es, input int em);
    checks++;
    if (out_valid !== ev || out_sign !== es || out_mag !== YW'(em)) begin
      errors++;
      $display("FAIL %s: got valid=%0b sign=%0b mag=%0d, expected valid=%0b sign=%0b mag=%0d",
               req, out_valid, out_sign, out_mag, ev, es, em);
    end
  endtask

  task automatic apply(input bit s, input int m);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_mag = XW'(m);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    bit es;
    int em;
    repeat (3) @(negedge clk);
    check("R8 reset state", 1'b0, 1'b0, 0);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][8], int'(VEC[i][7:0]));
      model(VEC[i][8], int'(VEC[i][7:0]), es, em);
      check("R1 table", 1'b1, es, em);
    end

    apply(1'b0, 0);   check("R1 x=0 gives a0", 1'b1, 1'b1, 96);
    apply(1'b1, 0);   check("R3 negative zero input", 1'b1, 1'b1, 96);
    apply(1'b0, 16);  check("R2 x=+1", 1'b1, 1'b1, 56);
    apply(1'b1, 16);  check("R2 x=-1 odd terms flip", 1'b1, 1'b1, 168);
    apply(1'b0, 32);  check("R4 exact cancel is positive zero", 1'b1, 1'b0, 0);
    apply(1'b0, 255); check("R5 positive saturation", 1'b1, 1'b0, 4095);
    apply(1'b1, 255); check("R5 negative saturation", 1'b1, 1'b1, 4095);

    apply(1'b0, 16);
    check("R6 valid one cycle after input", 1'b1, 1'b1, 56);
    in_sign = 1'b1; in_mag = 8'd100;
    @(negedge clk);
    check("R6 valid drops after idle cycle", 1'b0, 1'b1, 56);
    in_sign = 1'b0; in_mag = 8'd200;
    repeat (2) @(negedge clk);
    check("R7 output held while idle", 1'b0, 1'b1, 56);

    apply(1'b0, 255);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid-run reset", 1'b0, 1'b0, 0);
    rst = 1'b0;
    apply(1'b0, 32);  check("R4 after reset", 1'b1, 1'b0, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule